// File: doc/BRIEF.md
# Performance Monitor Counter Bank

The block holds four 32-bit event counters and one control register. Each counter has its own single-cycle event pulse input, and adds one for each pulse while counting is enabled. The top bit of a counter is its overflow flag, so a counter counts as overflowed once its value reaches 0x8000_0000. After that the counter keeps counting and wraps modulo 2^32.

An overflow raises an interrupt condition only when the global enable is set and the counter's own condition enable is also set. Counter 0 has a dedicated condition enable, and counters 1 to 3 share a second one. The condition is held as long as the state behind it persists. The interrupt output delivers it only while the external interrupt-enable input is high.

Two control bits shape counting. The freeze bit stops every counter while an interrupt condition is active. The trigger bit holds counters 1 to 3 idle until counter 0 goes negative. Software uses a single write and read port to load the counters and the control register and to read them back.

Top module: `perf_cnt_bank`

## Requirements
- R1: While `rst_ni` is low, all counters, the control register, `rdata_o` and `irq_o` are cleared to zero.
- R2: A pulse on `event_i[k]` while counting is enabled adds one to counter k only. The counter passes from 0x7FFF_FFFF to 0x8000_0000 and wraps from 0xFFFF_FFFF to 0.
- R3: A write to counter k in the same cycle as an event on counter k leaves counter k holding the written value.
- R4: `rdata_o` shows, one cycle after `addr_i` is presented, the value at that address. Addresses 0 to 3 select counters 0 to 3, address 4 selects the control register, and addresses 5 to 7 read as zero.
- R5: The control register has five bits: bit 0 is the global enable, bit 1 is the counter 0 condition enable, bit 2 is the shared condition enable for counters 1 to 3, bit 3 is freeze, and bit 4 is trigger. The upper bits are written as don't-care and read as zero.
- R6: The interrupt condition is true when the global enable is set and either (a) the counter 0 enable is set and bit 31 of counter 0 is set, or (b) the shared enable is set and bit 31 of any of counters 1 to 3 is set. Writing a value with bit 31 set raises the condition even though no event was counted.
- R7: `irq_o` is a register loaded with the interrupt condition ANDed with `ext_ie_i`. A condition that arises while `ext_ie_i` is low stays pending and appears on `irq_o` one cycle after `ext_ie_i` goes high.
- R8: When freeze is set and the interrupt condition is true, no counter increments.
- R9: When trigger is set, counters 1 to 3 ignore events until bit 31 of counter 0 is set.
- R10: Once trigger mode has released counters 1 to 3, they keep counting even if counter 0 drops below 0x8000_0000. The release ends only when the trigger bit is cleared.
- R11: `irq_o` falls after software writes every enabled overflowed counter to a value with bit 31 clear, or after it clears the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the address |
| event_i | input | 4 | Per-counter event pulses |
| ext_ie_i | input | 1 | External interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that a write strobe targets one address at a time. They also assume that `event_i` and `ext_ie_i` change only between clock edges and never carry unknown values after reset. The bench drives every input on the falling edge and holds it for whole cycles, so those assumptions hold. Each event pulse stays exactly one cycle wide unless a test means to apply a run of back-to-back events. The bench loads values near the sign boundary and the wrap boundary through the write port, which keeps its sweeps short.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int CTRL_W = 5;

  // bit 4 .. bit 0
  typedef struct packed {
    logic trig;
    logic frz;
    logic en_rest;
    logic en_first;
    logic glob;
  } ctrl_t;
endpackage

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  assert_write_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
  assert_inc_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/perf_cnt_ctrl.sv
module perf_cnt_ctrl
  import perf_cnt_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_CNT-1:0] msb_i,
  input  logic               ext_ie_i,
  output ctrl_t              ctrl_o,
  output logic [NUM_CNT-1:0] run_o,
  output logic               cond_o,
  output logic               irq_o
);
  logic released_q;
  logic gate_rest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_wr_i) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           released_q <= 1'b0;
    else if (!ctrl_o.trig) released_q <= 1'b0;
    else if (msb_i[0])     released_q <= 1'b1;
  end

  assign cond_o = ctrl_o.glob &
                  ((ctrl_o.en_first & msb_i[0]) | (ctrl_o.en_rest & |msb_i[NUM_CNT-1:1]));

  assign gate_rest = !ctrl_o.trig || released_q || msb_i[0];

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++)
      run_o[k] = !(ctrl_o.frz && cond_o) && (k == 0 || gate_rest);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= cond_o & ext_ie_i;
  end

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ext_ie_i));
  assert_irq_delivers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o && ext_ie_i) |=> irq_o);
  assert_release_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (released_q && ctrl_o.trig && !ctrl_wr_i) |=> released_q);
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
  import perf_cnt_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [NUM_CNT-1:0] event_i,
  input  logic               ext_ie_i,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT);

  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_CNT-1:0] msb, run, cnt_wr;
  logic               cond;
  ctrl_t              ctrl;
  logic [CNT_W-1:0]   rd_next;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign cnt_wr[k] = wr_en_i && (addr_i == ADDR_W'(k));
    assign msb[k]    = cnt[k][CNT_W-1];
    perf_cnt_slice #(.CNT_W(CNT_W)) u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cnt_wr[k]),
      .wdata_i(wdata_i),
      .inc_i  (event_i[k] && run[k]),
      .cnt_o  (cnt[k])
    );
  end

  perf_cnt_ctrl #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(wr_en_i && (addr_i == CTRL_ADDR)),
    .wdata_i  (wdata_i),
    .msb_i    (msb),
    .ext_ie_i (ext_ie_i),
    .ctrl_o   (ctrl),
    .run_o    (run),
    .cond_o   (cond),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (addr_i == ADDR_W'(k)) rd_next = cnt[k];
    if (addr_i == CTRL_ADDR) rd_next = CNT_W'(ctrl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  assert_freeze_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.frz && cond && !cnt_wr[0]) |=> $stable(cnt[0]));
  assert_trigger_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.trig && !$past(ctrl.trig) && !msb[0] && !cnt_wr[1]) |=> $stable(cnt[1]));
  assert_ctrl_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(addr_i == CTRL_ADDR) |-> rdata_o[CNT_W-1:CTRL_W] == '0);
endmodule

// File: tb/perf_cnt_bank_bench.sv
`timescale 1ns/1ps
module perf_cnt_bank_bench;
  logic        clk = 0, rst_ni = 0;
  logic        wr_en = 0, ext_ie = 1;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [3:0]  ev = 0;
  logic        irq;
  int total = 0, fails = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  perf_cnt_bank u_perf_cnt_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .ext_ie_i(ext_ie), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      ev = m; @(negedge clk);
    end
    ev = 0;
  endtask

  task automatic clear_cnts();
    for (int k = 0; k < 4; k++) wr(3'(k), 32'h0);
  endtask

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 0);
    check("R1 rdata in reset", rdata, 0);
    rst_ni = 1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); check("R1 reset value", v, 0); end
    // R4 unmapped addresses
    for (int a = 5; a < 8; a++) begin rd(3'(a), v); check("R4 unmapped reads zero", v, 0); end

    // R2 sweep each counter across the sign boundary and the wrap
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 5; n++) begin
        wr(3'(k), 32'h7FFF_FFFE);
        pulse(4'(1 << k), n);
        rd(3'(k), v); check("R2 count across sign", v, 32'h7FFF_FFFE + 32'(n));
      end
      wr(3'(k), 32'hFFFF_FFFF);
      pulse(4'(1 << k), 1);
      rd(3'(k), v); check("R2 wrap to zero", v, 0);
      pulse(4'(1 << k), 2);
      for (int j = 0; j < 4; j++) begin
        rd(3'(j), v); check("R2 only own counter", v, (j == k) ? 32'd2 : 32'd0);
      end
      wr(3'(k), 0);
    end

    // R3 write wins over same-cycle event
    for (int k = 0; k < 4; k++) begin
      wr(3'(k), 32'h10);
      wr_en = 1; addr = 3'(k); wdata = 32'h1234_0000 + 32'(k); ev = 4'(1 << k);
      @(negedge clk); wr_en = 0; ev = 0;
      rd(3'(k), v); check("R3 write wins", v, 32'h1234_0000 + 32'(k));
    end
    clear_cnts();

    // R5 control layout
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R5 ctrl masked", v, 32'h1F);
    wr(3'd4, 32'h15);        rd(3'd4, v); check("R5 ctrl readback", v, 32'h15);
    wr(3'd4, 0);

    // R6 enable and source sweep, overflow loaded by write
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic exp_irq;
        exp_irq = c[0] && ((k == 0) ? c[1] : c[2]);
        wr(3'd4, 32'(c));
        wr(3'(k), 32'h8000_0000);
        @(negedge clk);
        check("R6 condition from enables", irq, exp_irq);
        wr(3'(k), 0);
        @(negedge clk);
        check("R11 clear by write", irq, 0);
      end
    end

    // R7 pending while external enable low
    wr(3'd4, 32'h03);
    ext_ie = 0;
    wr(3'd0, 32'h8000_0005);
    repeat (3) @(negedge clk);
    check("R7 masked while ie low", irq, 0);
    ext_ie = 1;
    @(negedge clk);
    check("R7 delivered after ie high", irq, 1);
    wr(3'd4, 32'h02);
    @(negedge clk);
    check("R11 clear by global enable", irq, 0);
    clear_cnts();

    // R8 freeze on condition
    wr(3'd4, 32'h0B);
    wr(3'd0, 32'h7FFF_FFFE);
    pulse(4'hF, 5);
    rd(3'd0, v); check("R8 counter 0 frozen", v, 32'h8000_0000);
    for (int k = 1; k < 4; k++) begin rd(3'(k), v); check("R8 others frozen", v, 2); end
    wr(3'd4, 0);
    clear_cnts();

    // R9 trigger holds counters 1..3
    wr(3'd4, 32'h10);
    pulse(4'hF, 3);
    rd(3'd0, v); check("R9 counter 0 runs", v, 3);
    for (int k = 1; k < 4; k++) begin rd(3'(k), v); check("R9 held idle", v, 0); end
    wr(3'd0, 32'h7FFF_FFFF);
    pulse(4'hF, 2);
    for (int k = 1; k < 4; k++) begin rd(3'(k), v); check("R9 released after sign", v, 1); end
    // R10 release persists
    wr(3'd0, 0);
    pulse(4'hF, 2);
    for (int k = 1; k < 4; k++) begin rd(3'(k), v); check("R10 keeps counting", v, 3); end
    wr(3'd4, 0);
    wr(3'd4, 32'h10);
    pulse(4'hE, 2);
    for (int k = 1; k < 4; k++) begin rd(3'(k), v); check("R10 release ends on clear", v, 3); end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule